// File: doc/BRIEF.md
# Serial Display-Link Transmitter Power Sequencer

This block steps the enable controls of a serial display-link transmitter through a fixed power-up and power-down order, so that the transmitter's bias, PLL, PHY and output stages never see an illegal combination. A power-up request first takes the data lanes and the clock lane out of standby. The block then walks through the stages that the configuration straps call for, one stage per clock at the least, and holds off the final output release until an internal PLL has had time to settle.

Four static straps pick the variant: an older-generation transmitter, a transmitter with a power-down control bit, a transmitter that needs an explicit PHY enable, and a transmitter clocked from an external PLL. A microsecond tick input times the PLL settle wait. A power-down request clears the controls in the reverse order. If it arrives while power-up is still running, the block abandons power-up and clears only the bits that are already set. `busy` is high while a sequence is in progress. `ready` is high once the output has been released.

Top module: `txlink_pwrseq`

## Requirements
- R1: After reset, every control output, `busy` and `ready` are low.
- R2: A power-up request (`enReq` high in idle) first raises all `laneOn` bits and `clkLaneOn` together, with every other control bit still low.
- R3: With `cfgLegacy` high, the next step raises `biasEn` and `phyEn` in the same cycle.
- R4: With `cfgExtPll` low, the next step raises `pllOn` alone. With `cfgExtPll` high, `pllOn` stays low at all times and the settle wait is skipped.
- R5: With `cfgHasPwrDn` high, the next step raises `pwrNormal` alone.
- R6: With `cfgNeedPhyEn` high and `cfgHasPwrDn` low (and `cfgLegacy` low), `phyEn` rises alone as the step before output release. With both `cfgNeedPhyEn` and `cfgHasPwrDn` high, `phyEn` rises only in the cycle in which `outRel` rises.
- R7: `outRel` is the last bit to rise. With an internal PLL it rises only after at least `SETTLE_US` and at most 1.5 x `SETTLE_US` ticks following the preceding step. `ready` rises in the same cycle as `outRel`.
- R8: Each step changes the outputs in a clock cycle of its own, so the number of distinct output changes during power-up is 2 + cfgLegacy + !cfgExtPll + cfgHasPwrDn + (cfgNeedPhyEn and not cfgHasPwrDn and not cfgLegacy).
- R9: A power-down request clears `outRel` first, then `phyEn` (when cfgNeedPhyEn), then `pwrNormal` (when present), then `pllOn` (when internal), each in its own cycle. A final step then clears all remaining controls and the lane bits, and the block returns to idle.
- R10: A power-down request during power-up abandons it. Only bits already set are cleared, in the R9 order, and `outRel` and `ready` never rise.
- R11: `disReq` in idle, and `enReq` while ready or while powering down, have no effect on the outputs.
- R12: `busy` is high during every power-up and power-down step, and it is never high together with `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enReq | input | 1 | Power-up request |
| disReq | input | 1 | Power-down request (wins over enReq) |
| usTick | input | 1 | One-cycle pulse every microsecond |
| cfgLegacy | input | 1 | Older-generation transmitter strap |
| cfgHasPwrDn | input | 1 | Power-down control bit present |
| cfgNeedPhyEn | input | 1 | Explicit PHY enable required |
| cfgExtPll | input | 1 | Transmitter clocked by an external PLL |
| laneOn | output | NUM_LANES | Data lanes out of standby |
| clkLaneOn | output | 1 | Clock lane out of standby |
| pllOn | output | 1 | Internal PLL enable |
| pwrNormal | output | 1 | Normal (not power-down) mode |
| phyEn | output | 1 | PHY / link enable |
| biasEn | output | 1 | Bias circuitry enable |
| outRel | output | 1 | Output release |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Output released, link up |

## Verification
A wrong state register makes the outputs skip a step, merge two steps into one cycle, or reverse two steps. The count and order of output changes then differ from the expected list, and this shows within the cycles of a single sequence. A settle counter that loads or stops at the wrong value moves the rise of `outRel` outside its tick window. A wrong down-step enable leaves a bit set after idle, or clears bits out of order, and this shows within the next few cycles after the request.

// File: rtl/txlink_pwrseq_pkg.sv
package txlink_pwrseq_pkg;

  localparam int UP_STEPS = 6;  // bias, pll, pwd, phy, wait, on
  localparam int DN_STEPS = 4;  // out, phy, pwd, pll

  typedef enum logic [3:0] {
    S_IDLE, S_LANES, S_BIAS, S_PLL, S_PWD, S_PHY, S_WAIT, S_ON,
    S_DOUT, S_DPHY, S_DPWD, S_DPLL
  } seqState_t;

  typedef struct packed {
    logic setLanes;
    logic setBias;
    logic setPll;
    logic setPwd;
    logic setPhy;
    logic setOut;
    logic loadTimer;
    logic clrOut;
    logic clrPhy;
    logic clrPwd;
    logic clrPll;
    logic clrAll;
  } seqStb_t;

endpackage

// File: rtl/txlink_pwrseq_ctrl.sv
module txlink_pwrseq_ctrl
  import txlink_pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enReq,
  input  logic    disReq,
  input  logic    cfgLegacy,
  input  logic    cfgHasPwrDn,
  input  logic    cfgNeedPhyEn,
  input  logic    cfgExtPll,
  input  logic    outRel,
  input  logic    phyEn,
  input  logic    pwrNormal,
  input  logic    pllOn,
  input  logic    timerDone,
  output seqStb_t stb,
  output logic    busy,
  output logic    ready
);

  seqState_t state, nxt;
  logic [UP_STEPS:1] upEn;
  logic [DN_STEPS:1] dnEn;
  logic isDown;
  int upOrd, dnOrd, tgt;

  // Steps that apply under the current straps, in power-up order
  always_comb begin
    upEn[1] = cfgLegacy;
    upEn[2] = !cfgExtPll;
    upEn[3] = cfgHasPwrDn;
    upEn[4] = cfgNeedPhyEn && !cfgHasPwrDn && !cfgLegacy;
    upEn[5] = !cfgExtPll;
    upEn[6] = 1'b1;
    dnEn[1] = outRel;
    dnEn[2] = cfgNeedPhyEn && phyEn;
    dnEn[3] = pwrNormal;
    dnEn[4] = pllOn;
  end

  always_comb begin
    case (state)
      S_BIAS:  upOrd = 1;
      S_PLL:   upOrd = 2;
      S_PWD:   upOrd = 3;
      S_PHY:   upOrd = 4;
      S_WAIT:  upOrd = 5;
      default: upOrd = 0;
    endcase
    case (state)
      S_DOUT:  dnOrd = 1;
      S_DPHY:  dnOrd = 2;
      S_DPWD:  dnOrd = 3;
      S_DPLL:  dnOrd = 4;
      default: dnOrd = 0;
    endcase
    isDown = state inside {S_DOUT, S_DPHY, S_DPWD, S_DPLL};
  end

  always_comb begin
    stb = '0;
    nxt = state;
    tgt = 0;
    if (state == S_IDLE) begin
      if (enReq && !disReq) begin
        stb.setLanes = 1'b1;
        nxt = S_LANES;
      end
    end else if (isDown || disReq) begin
      tgt = DN_STEPS + 1;
      for (int i = DN_STEPS; i >= 1; i--)
        if (dnEn[i] && i > dnOrd) tgt = i;
      case (tgt)
        1: begin stb.clrOut = 1'b1; nxt = S_DOUT; end
        2: begin stb.clrPhy = 1'b1; nxt = S_DPHY; end
        3: begin stb.clrPwd = 1'b1; nxt = S_DPWD; end
        4: begin stb.clrPll = 1'b1; nxt = S_DPLL; end
        default: begin stb.clrAll = 1'b1; nxt = S_IDLE; end
      endcase
    end else if (state != S_ON && !(state == S_WAIT && !timerDone)) begin
      tgt = UP_STEPS;
      for (int i = UP_STEPS; i >= 1; i--)
        if (upEn[i] && i > upOrd) tgt = i;
      case (tgt)
        1: begin stb.setBias = 1'b1; nxt = S_BIAS; end
        2: begin stb.setPll = 1'b1; nxt = S_PLL; end
        3: begin stb.setPwd = 1'b1; nxt = S_PWD; end
        4: begin stb.setPhy = 1'b1; nxt = S_PHY; end
        5: begin stb.loadTimer = 1'b1; nxt = S_WAIT; end
        default: begin
          stb.setOut = 1'b1;
          stb.setPhy = cfgNeedPhyEn && cfgHasPwrDn;
          nxt = S_ON;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy  = (state != S_IDLE) && (state != S_ON);
  assign ready = (state == S_ON);

endmodule

// File: rtl/txlink_pwrseq_dp.sv
module txlink_pwrseq_dp
  import txlink_pwrseq_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SETTLE_US = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStb_t              stb,
  input  logic                 usTick,
  output logic [NUM_LANES-1:0] laneOn,
  output logic                 clkLaneOn,
  output logic                 pllOn,
  output logic                 pwrNormal,
  output logic                 phyEn,
  output logic                 biasEn,
  output logic                 outRel,
  output logic                 timerDone
);

  // One extra tick absorbs the partial microsecond at load time
  localparam int TICKS = SETTLE_US + 1;
  localparam int TW    = $clog2(TICKS + 1);

  logic [TW-1:0] tCnt;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             laneOn[g] <= 1'b0;
      else if (stb.clrAll)   laneOn[g] <= 1'b0;
      else if (stb.setLanes) laneOn[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkLaneOn <= 1'b0;
      pllOn     <= 1'b0;
      pwrNormal <= 1'b0;
      phyEn     <= 1'b0;
      biasEn    <= 1'b0;
      outRel    <= 1'b0;
    end else if (stb.clrAll) begin
      clkLaneOn <= 1'b0;
      pllOn     <= 1'b0;
      pwrNormal <= 1'b0;
      phyEn     <= 1'b0;
      biasEn    <= 1'b0;
      outRel    <= 1'b0;
    end else begin
      if (stb.setLanes) clkLaneOn <= 1'b1;
      if (stb.setBias) begin
        biasEn <= 1'b1;
        phyEn  <= 1'b1;
      end
      if (stb.setPll) pllOn     <= 1'b1;
      if (stb.clrPll) pllOn     <= 1'b0;
      if (stb.setPwd) pwrNormal <= 1'b1;
      if (stb.clrPwd) pwrNormal <= 1'b0;
      if (stb.setPhy) phyEn     <= 1'b1;
      if (stb.clrPhy) phyEn     <= 1'b0;
      if (stb.setOut) outRel    <= 1'b1;
      if (stb.clrOut) outRel    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           tCnt <= '0;
    else if (stb.loadTimer)              tCnt <= '0;
    else if (usTick && tCnt != TW'(TICKS)) tCnt <= tCnt + 1'b1;
  end

  assign timerDone = (tCnt == TW'(TICKS));

endmodule

// File: rtl/txlink_pwrseq.sv
module txlink_pwrseq
  import txlink_pwrseq_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SETTLE_US = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enReq,
  input  logic                 disReq,
  input  logic                 usTick,
  input  logic                 cfgLegacy,
  input  logic                 cfgHasPwrDn,
  input  logic                 cfgNeedPhyEn,
  input  logic                 cfgExtPll,
  output logic [NUM_LANES-1:0] laneOn,
  output logic                 clkLaneOn,
  output logic                 pllOn,
  output logic                 pwrNormal,
  output logic                 phyEn,
  output logic                 biasEn,
  output logic                 outRel,
  output logic                 busy,
  output logic                 ready
);

  seqStb_t stb;
  logic    timerDone;

  txlink_pwrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .cfgLegacy(cfgLegacy), .cfgHasPwrDn(cfgHasPwrDn),
    .cfgNeedPhyEn(cfgNeedPhyEn), .cfgExtPll(cfgExtPll),
    .outRel(outRel), .phyEn(phyEn), .pwrNormal(pwrNormal), .pllOn(pllOn),
    .timerDone(timerDone), .stb(stb), .busy(busy), .ready(ready)
  );

  txlink_pwrseq_dp #(.NUM_LANES(NUM_LANES), .SETTLE_US(SETTLE_US)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .usTick(usTick),
    .laneOn(laneOn), .clkLaneOn(clkLaneOn), .pllOn(pllOn),
    .pwrNormal(pwrNormal), .phyEn(phyEn), .biasEn(biasEn),
    .outRel(outRel), .timerDone(timerDone)
  );

endmodule

// File: rtl/txlink_pwrseq_chk.sv
module txlink_pwrseq_chk #(
  parameter int NUM_LANES = 4,
  parameter int SETTLE_US = 100
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 usTick,
  input logic                 cfgLegacy,
  input logic                 cfgHasPwrDn,
  input logic                 cfgNeedPhyEn,
  input logic                 cfgExtPll,
  input logic [NUM_LANES-1:0] laneOn,
  input logic                 clkLaneOn,
  input logic                 pllOn,
  input logic                 pwrNormal,
  input logic                 phyEn,
  input logic                 biasEn,
  input logic                 outRel,
  input logic                 busy,
  input logic                 ready
);

  logic [15:0] pllTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pllTicks <= '0;
    else if (!pllOn)                   pllTicks <= '0;
    else if (usTick && pllTicks != '1) pllTicks <= pllTicks + 1'b1;
  end

  // R2
  lanes_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkLaneOn) |-> (&laneOn) && !pllOn && !biasEn && !pwrNormal && !phyEn && !outRel);

  // R3
  bias_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(biasEn) |-> $rose(phyEn) && cfgLegacy);

  // R4
  ext_pll_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgExtPll |-> !pllOn);

  // R6
  phy_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHasPwrDn && cfgNeedPhyEn && !cfgLegacy && $rose(phyEn)) |-> $rose(outRel));

  // R7
  settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outRel) && !cfgExtPll) |-> (int'(pllTicks) >= SETTLE_US));

  // R7
  out_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outRel) |-> clkLaneOn && (cfgExtPll || pllOn) && (pwrNormal == cfgHasPwrDn));

  // R9
  pll_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllOn) |-> !outRel && !pwrNormal);

  // R9
  pwd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrNormal) |-> !outRel && !(cfgNeedPhyEn && phyEn));

  // R12
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> outRel && !busy);

endmodule

bind txlink_pwrseq txlink_pwrseq_chk #(.NUM_LANES(NUM_LANES), .SETTLE_US(SETTLE_US)) u_chk (
  .clk(clk), .rstN(rstN), .usTick(usTick),
  .cfgLegacy(cfgLegacy), .cfgHasPwrDn(cfgHasPwrDn),
  .cfgNeedPhyEn(cfgNeedPhyEn), .cfgExtPll(cfgExtPll),
  .laneOn(laneOn), .clkLaneOn(clkLaneOn), .pllOn(pllOn),
  .pwrNormal(pwrNormal), .phyEn(phyEn), .biasEn(biasEn),
  .outRel(outRel), .busy(busy), .ready(ready)
);

// File: tb/tb_txlink_pwrseq.sv
module tb_txlink_pwrseq;

  localparam int SETTLE = 100;
  localparam int NROWS  = 9;

  // {straps(legacy,hasPwr,needPhy,extPll), upChanges, downChanges, final {out,phy,bias,pwr,pll}}
  localparam logic [16:0] ROWS [NROWS] = '{
    {4'b0000, 4'd3, 4'd3, 5'b10001},
    {4'b0001, 4'd2, 4'd2, 5'b10000},
    {4'b0100, 4'd4, 4'd4, 5'b10011},
    {4'b0110, 4'd4, 4'd5, 5'b11011},
    {4'b0010, 4'd4, 4'd4, 5'b11001},
    {4'b0111, 4'd3, 4'd4, 5'b11010},
    {4'b1000, 4'd4, 4'd3, 5'b11101},
    {4'b1011, 4'd3, 4'd3, 5'b11100},
    {4'b1110, 4'd5, 4'd5, 5'b11111}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enReq = 1'b0, disReq = 1'b0, usTick = 1'b0;
  logic cfgLegacy = 1'b0, cfgHasPwrDn = 1'b0, cfgNeedPhyEn = 1'b0, cfgExtPll = 1'b0;
  logic [3:0] laneOn;
  logic clkLaneOn, pllOn, pwrNormal, phyEn, biasEn, outRel, busy, ready;
  logic [9:0] word;
  int tests = 0, fails = 0, tickPh = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    tickPh = (tickPh == 2) ? 0 : tickPh + 1;
    usTick = (tickPh == 0);
  end

  txlink_pwrseq #(.NUM_LANES(4), .SETTLE_US(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq), .usTick(usTick),
    .cfgLegacy(cfgLegacy), .cfgHasPwrDn(cfgHasPwrDn),
    .cfgNeedPhyEn(cfgNeedPhyEn), .cfgExtPll(cfgExtPll),
    .laneOn(laneOn), .clkLaneOn(clkLaneOn), .pllOn(pllOn),
    .pwrNormal(pwrNormal), .phyEn(phyEn), .biasEn(biasEn),
    .outRel(outRel), .busy(busy), .ready(ready)
  );

  assign word = {outRel, phyEn, biasEn, pwrNormal, pllOn, clkLaneOn, laneOn};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runRow(input logic [16:0] row);
    logic [9:0] snaps [8];
    logic [9:0] prev, upWord, dn0;
    int n, m, tickAcc, waitT, guard;
    bit sawBusy;
    {cfgLegacy, cfgHasPwrDn, cfgNeedPhyEn, cfgExtPll} = row[16:13];
    repeat (2) @(negedge clk);
    prev = word; n = 0; tickAcc = 0; waitT = 0; sawBusy = 0; guard = 0;
    enReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0;
    while (!ready && guard < 3000) begin
      if (busy) sawBusy = 1;
      if (word != prev) begin
        if (n < 8) snaps[n] = word;
        n++;
        if (word[9] && !prev[9]) waitT = tickAcc;
        tickAcc = 0;
        prev = word;
      end
      if (usTick) tickAcc++;
      guard++;
      @(negedge clk);
    end
    if (word != prev) begin
      if (n < 8) snaps[n] = word;
      n++;
      if (word[9] && !prev[9]) waitT = tickAcc;
    end
    upWord = word;
    // R2 lanes and clock lane released first, alone
    chk(snaps[0] == 10'h01F, "R2 first step", snaps[0], 10'h01F);
    // R3 legacy bias + phy together
    if (cfgLegacy) chk(snaps[1] == 10'h19F, "R3 bias/phy pair", snaps[1], 10'h19F);
    // R4 internal PLL step adds only pllOn
    if (!cfgExtPll) begin
      int p = cfgLegacy ? 2 : 1;
      chk(snaps[p] == (snaps[p-1] | 10'h020), "R4 pll step", snaps[p], snaps[p-1] | 10'h020);
    end
    chk(upWord[5] == !cfgExtPll, "R4 pll final", upWord[5], !cfgExtPll);
    // R5 power-down bit step
    if (cfgHasPwrDn && n >= 3)
      chk(snaps[n-2][6] && !snaps[n-3][6], "R5 pwd step", snaps[n-2], snaps[n-3]);
    // R6 phy enable placement
    if (cfgNeedPhyEn && cfgHasPwrDn && !cfgLegacy && n >= 2)
      chk(!snaps[n-2][8] && snaps[n-1][8], "R6 phy with out", snaps[n-1], snaps[n-2]);
    if (cfgNeedPhyEn && !cfgHasPwrDn && !cfgLegacy && n >= 2)
      chk(snaps[n-2][8] && snaps[n-1] == (snaps[n-2] | 10'h200), "R6 phy before out",
          snaps[n-1], snaps[n-2]);
    // R8 one distinct change per step
    chk(n == int'(row[12:9]), "R8 step count", n, row[12:9]);
    // R7 final word, ready, settle window
    chk(ready && upWord[9:5] == row[4:0], "R7 final state", upWord[9:5], row[4:0]);
    if (!cfgExtPll)
      chk(waitT >= SETTLE && waitT <= SETTLE * 3 / 2, "R7 settle ticks", waitT, SETTLE);
    // R12 busy during, not after
    chk(sawBusy && !busy, "R12 busy", {sawBusy, busy}, 2'b10);

    prev = word; m = 0; guard = 0; dn0 = '0;
    disReq = 1'b1;
    @(negedge clk);
    disReq = 1'b0;
    while (!(!busy && word == 0) && guard < 100) begin
      if (word != prev) begin
        if (m == 0) dn0 = word;
        m++;
        prev = word;
      end
      guard++;
      @(negedge clk);
    end
    if (word != prev) m++;
    // R9 down order and count
    chk(dn0 == (upWord & ~10'h200), "R9 out cleared first", dn0, upWord & ~10'h200);
    chk(m == int'(row[8:5]), "R9 down step count", m, row[8:5]);
    chk(word == 0 && !ready && !busy, "R9 idle after down", word, 0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finishRun();
    end
  end

  initial begin
    logic [9:0] prev, first, w;
    int m, guard;
    bit sawOut;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(word == 0 && !busy && !ready, "R1 reset", {word, busy, ready}, 0);

    // R11 disable in idle has no effect
    disReq = 1'b1;
    @(negedge clk);
    disReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(word == 0 && !busy && !ready, "R11 disReq idle", {word, busy}, 0);

    for (int r = 0; r < NROWS; r++) runRow(ROWS[r]);

    // R10 abort after PLL step
    {cfgLegacy, cfgHasPwrDn, cfgNeedPhyEn, cfgExtPll} = 4'b0100;
    repeat (2) @(negedge clk);
    enReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0;
    guard = 0;
    while (!pllOn && guard < 20) begin guard++; @(negedge clk); end
    prev = word; disReq = 1'b1;
    @(negedge clk);
    disReq = 1'b0;
    m = 0; guard = 0; sawOut = 0; first = '0;
    while (!(!busy && word == 0) && guard < 50) begin
      if (outRel || ready) sawOut = 1;
      if (word != prev) begin
        if (m == 0) first = word;
        m++;
        prev = word;
      end
      guard++;
      @(negedge clk);
    end
    if (word != prev) m++;
    chk(first == 10'h01F, "R10 abort first clear", first, 10'h01F);
    chk(m == 2 && !sawOut, "R10 abort steps", m, 2);
    chk(word == 0 && !busy, "R10 abort idle", word, 0);

    // R11 enReq while ready, then during power-down
    {cfgLegacy, cfgHasPwrDn, cfgNeedPhyEn, cfgExtPll} = 4'b0000;
    repeat (2) @(negedge clk);
    enReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0;
    guard = 0;
    while (!ready && guard < 3000) begin guard++; @(negedge clk); end
    w = word;
    enReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(word == w && ready, "R11 enReq while ready", word, w);
    disReq = 1'b1;
    @(negedge clk);
    disReq = 1'b0;
    enReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0;
    guard = 0;
    while (busy && guard < 50) begin guard++; @(negedge clk); end
    repeat (3) @(negedge clk);
    chk(word == 0 && !busy && !ready, "R11 enReq during down", word, 0);

    done = 1;
    finishRun();
  end

endmodule